// File: doc/BRIEF.md
# Interleaved Host-Offset Decoder

This block turns an address offset inside an interleaved memory region into the two facts a memory target needs: which member of the interleave set owns the address (its position), and where inside that member's own address space the data lives (the device offset). A request carries a 52-bit host offset, a 4-bit ways code and a 4-bit granule code. The response returns the position, the device offset and an error flag.

Sets of 1, 2, 4, 8 or 16 members are decoded in a single cycle by pulling the position out as a bit field and closing the gap it leaves. Sets of 3, 6 or 12 members cannot be handled that way. For these, the block runs a sequential divide-by-three over the upper offset bits, and both the position and the device offset are built from the quotient and the remainder. Requests and responses each use a valid/ready handshake. Only one request is in flight at a time.

Top module: `ilv_hpa_decoder`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: For a valid request with granule code g, device offset bits [g+7:0] equal host offset bits [g+7:0]. The granule size is 256 << g bytes, and the valid granule codes are 0 to 6.
- R3: Ways codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 members. With code w, the position is host bits [g+8+w-1 : g+8]. Code 0 always gives position 0.
- R4: For ways codes 0 to 4, device offset bits [51:g+8] equal host offset bits [51:g+w+8]. The result is zero-filled above bit 51.
- R5: Ways codes 8, 9 and 10 select 3, 6 and 12 members. The position is (host >> (g+8)) modulo the member count.
- R6: For ways codes 8, 9 and 10, device offset bits from g+8 upward equal (host >> (g+w)) / 3, where w is the ways code itself.
- R7: A ways code of 5, 6, 7 or 11 to 15, or a granule code of 7 to 15, gives `rsp_err`=1, a device offset of all ones and position 0. Valid requests give `rsp_err`=0.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response is taken.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold their values and `rsp_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_ofs | input | 52 | Host offset within the region |
| req_ways_code | input | 4 | Encoded member count |
| req_gran_code | input | 4 | Encoded granule size |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pos | output | 4 | Owning member position |
| rsp_dev_ofs | output | 52 | Device-local offset |
| rsp_err | output | 1 | Invalid code seen |

## Verification
A corrupted divider remainder or quotient shows up only on three-based sets. It appears as a wrong position or wrong upper device bits on the first such response, about 52 cycles after acceptance. The low pass-through bits stay correct even then. A wrong control state appears at the handshake within one cycle: `req_ready` is raised while a response is pending, or a held response changes under backpressure. Swapped shift amounts show up at once on power-of-two responses as a misplaced position field.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int WCODE_W   = 4;
    localparam int GCODE_W   = 4;
    localparam int POS_W     = 4;
    localparam int GRAN_BASE = 8;
    localparam int MAX_GCODE = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_RESP = 2'd2
    } ilv_state_e;
endpackage

// File: rtl/ilv_code_decode.sv
module ilv_code_decode
    import ilv_pkg::*;
(
    input  logic [WCODE_W-1:0] ways_code,
    input  logic [GCODE_W-1:0] gran_code,
    output logic               codes_ok,
    output logic               three_mode,
    output logic [2:0]         pow2_log,
    output logic [1:0]         three_log
);
    logic ways_ok;

    always_comb begin
        ways_ok    = 1'b0;
        three_mode = 1'b0;
        pow2_log   = 3'd0;
        three_log  = 2'd0;
        case (ways_code)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4: begin
                ways_ok  = 1'b1;
                pow2_log = ways_code[2:0];
            end
            4'd8, 4'd9, 4'd10: begin
                ways_ok    = 1'b1;
                three_mode = 1'b1;
                three_log  = ways_code[1:0];
            end
            default: ways_ok = 1'b0;
        endcase
        codes_ok = ways_ok && (gran_code <= GCODE_W'(MAX_GCODE));
    end
endmodule

// File: rtl/ilv_pow2_split.sv
module ilv_pow2_split
    import ilv_pkg::*;
#(
    parameter int OFS_W = 52
) (
    input  logic [OFS_W-1:0] host_ofs,
    input  logic [2:0]       ways_log,
    input  logic [2:0]       gran_log,
    output logic [POS_W-1:0] pos,
    output logic [OFS_W-1:0] dev_ofs
);
    localparam int SH_W = $clog2(OFS_W) + 1;

    logic [SH_W-1:0]  lo_cut;
    logic [SH_W-1:0]  hi_cut;
    logic [OFS_W-1:0] low_mask;
    logic [OFS_W-1:0] field;
    logic [POS_W-1:0] pos_mask;

    always_comb begin
        lo_cut   = SH_W'(gran_log) + SH_W'(GRAN_BASE);
        hi_cut   = lo_cut + SH_W'(ways_log);
        low_mask = ~({OFS_W{1'b1}} << lo_cut);
        field    = host_ofs >> lo_cut;
        pos_mask = ~({POS_W{1'b1}} << ways_log);
        pos      = field[POS_W-1:0] & pos_mask;
        dev_ofs  = ((host_ofs >> hi_cut) << lo_cut) | (host_ofs & low_mask);
    end
endmodule

// File: rtl/ilv_div3.sv
module ilv_div3 #(
    parameter int DATA_W       = 52,
    parameter int BITS_PER_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    output logic              done,
    output logic [DATA_W-1:0] quot,
    output logic [1:0]        rem
);
    localparam int STEPS = (DATA_W + BITS_PER_CYC - 1) / BITS_PER_CYC;
    localparam int PAD_W = STEPS * BITS_PER_CYC;
    localparam int CNT_W = $clog2(STEPS + 1);

    typedef struct packed {
        logic [PAD_W-1:0] work;
        logic [1:0]       rem;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        logic [2:0] trial;
        logic       qbit;
        trial = 3'd0;
        qbit  = 1'b0;
        div_d = div_q;
        div_d.done = 1'b0;
        if (start) begin
            div_d.work = PAD_W'(dividend);
            div_d.rem  = 2'd0;
            div_d.cnt  = CNT_W'(STEPS);
            div_d.busy = 1'b1;
        end else if (div_q.busy) begin
            for (int i = 0; i < BITS_PER_CYC; i++) begin
                trial = {div_d.rem, div_d.work[PAD_W-1]};
                if (trial >= 3'd3) begin
                    trial = trial - 3'd3;
                    qbit  = 1'b1;
                end else begin
                    qbit  = 1'b0;
                end
                div_d.rem  = trial[1:0];
                div_d.work = {div_d.work[PAD_W-2:0], qbit};
            end
            div_d.cnt = div_q.cnt - CNT_W'(1);
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done = div_q.done;
    assign quot = div_q.work[DATA_W-1:0];
    assign rem  = div_q.rem;
endmodule

// File: rtl/ilv_hpa_decoder.sv
module ilv_hpa_decoder
    import ilv_pkg::*;
#(
    parameter int OFS_W            = 52,
    parameter int DIV_BITS_PER_CYC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [OFS_W-1:0]   req_ofs,
    input  logic [WCODE_W-1:0] req_ways_code,
    input  logic [GCODE_W-1:0] req_gran_code,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [POS_W-1:0]   rsp_pos,
    output logic [OFS_W-1:0]   rsp_dev_ofs,
    output logic               rsp_err
);
    localparam int SH_W = $clog2(OFS_W) + 1;

    typedef struct packed {
        ilv_state_e       st;
        logic [OFS_W-1:0] host;
        logic [2:0]       glog;
        logic [1:0]       klog;
        logic [POS_W-1:0] pos;
        logic [OFS_W-1:0] dev;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             codes_ok, three_mode;
    logic [2:0]       pow2_log;
    logic [1:0]       three_log;
    logic [POS_W-1:0] p2_pos;
    logic [OFS_W-1:0] p2_dev;
    logic             div_start, div_done;
    logic [OFS_W-1:0] div_in, div_quot;
    logic [1:0]       div_rem;
    logic             accept;

    ilv_code_decode u_decode (
        .ways_code (req_ways_code),
        .gran_code (req_gran_code),
        .codes_ok  (codes_ok),
        .three_mode(three_mode),
        .pow2_log  (pow2_log),
        .three_log (three_log)
    );

    ilv_pow2_split #(.OFS_W(OFS_W)) u_pow2 (
        .host_ofs(req_ofs),
        .ways_log(pow2_log),
        .gran_log(req_gran_code[2:0]),
        .pos     (p2_pos),
        .dev_ofs (p2_dev)
    );

    ilv_div3 #(.DATA_W(OFS_W), .BITS_PER_CYC(DIV_BITS_PER_CYC)) u_div3 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .dividend(div_in),
        .done    (div_done),
        .quot    (div_quot),
        .rem     (div_rem)
    );

    always_comb begin
        logic [SH_W-1:0]  lo_cut;
        logic [OFS_W-1:0] low_mask;
        logic [OFS_W-1:0] upper_field;
        logic [POS_W-1:0] k_mask;

        ctl_d       = ctl_q;
        req_ready   = (ctl_q.st == ST_IDLE);
        accept      = req_valid && req_ready;
        div_start   = accept && codes_ok && three_mode;
        div_in      = req_ofs >> (SH_W'(req_gran_code[2:0]) + SH_W'(req_ways_code));

        lo_cut      = SH_W'(ctl_q.glog) + SH_W'(GRAN_BASE);
        low_mask    = ~({OFS_W{1'b1}} << lo_cut);
        upper_field = ctl_q.host >> lo_cut;
        k_mask      = ~({POS_W{1'b1}} << ctl_q.klog);

        case (ctl_q.st)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.host = req_ofs;
                    ctl_d.glog = req_gran_code[2:0];
                    ctl_d.klog = three_log;
                    if (!codes_ok) begin
                        ctl_d.err = 1'b1;
                        ctl_d.pos = '0;
                        ctl_d.dev = '1;
                        ctl_d.st  = ST_RESP;
                    end else if (three_mode) begin
                        ctl_d.err = 1'b0;
                        ctl_d.st  = ST_DIV;
                    end else begin
                        ctl_d.err = 1'b0;
                        ctl_d.pos = p2_pos;
                        ctl_d.dev = p2_dev;
                        ctl_d.st  = ST_RESP;
                    end
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    ctl_d.pos = (POS_W'(div_rem) << ctl_q.klog)
                              | (upper_field[POS_W-1:0] & k_mask);
                    ctl_d.dev = (div_quot << lo_cut) | (ctl_q.host & low_mask);
                    ctl_d.st  = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign rsp_valid   = (ctl_q.st == ST_RESP);
    assign rsp_pos     = ctl_q.pos;
    assign rsp_dev_ofs = ctl_q.dev;
    assign rsp_err     = ctl_q.err;
endmodule

// File: rtl/ilv_hpa_decoder_chk.sv
module ilv_hpa_decoder_chk
    import ilv_pkg::*;
#(
    parameter int OFS_W = 52
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [OFS_W-1:0]   req_ofs,
    input logic [WCODE_W-1:0] req_ways_code,
    input logic [GCODE_W-1:0] req_gran_code,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [POS_W-1:0]   rsp_pos,
    input logic [OFS_W-1:0]   rsp_dev_ofs,
    input logic               rsp_err
);
    logic [OFS_W-1:0]   cap_ofs;
    logic [WCODE_W-1:0] cap_w;
    logic [GCODE_W-1:0] cap_g;

    function automatic logic codes_bad(logic [WCODE_W-1:0] w, logic [GCODE_W-1:0] g);
        return !((w <= 4'd4) || (w >= 4'd8 && w <= 4'd10)) || (g > 4'd6);
    endfunction

    function automatic logic [4:0] member_count(logic [WCODE_W-1:0] w);
        if (w <= 4'd4) return 5'd1 << w;
        return 5'd3 << (w - 4'd8);
    endfunction

    function automatic logic [OFS_W-1:0] keep_mask(logic [GCODE_W-1:0] g);
        return ~({OFS_W{1'b1}} << (g[2:0] + 4'd8));
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ofs <= '0;
            cap_w   <= '0;
            cap_g   <= '0;
        end else if (req_valid && req_ready) begin
            cap_ofs <= req_ofs;
            cap_w   <= req_ways_code;
            cap_g   <= req_gran_code;
        end
    end

    // R8
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R8
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pos)
                                       && $stable(rsp_dev_ofs) && $stable(rsp_err)));

    // R7
    err_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ((rsp_dev_ofs == '1) && (rsp_pos == '0)));

    // R7
    err_matches_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err == codes_bad(cap_w, cap_g)));

    // R2
    low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> (((rsp_dev_ofs ^ cap_ofs) & keep_mask(cap_g)) == '0));

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> ({1'b0, rsp_pos} < member_count(cap_w)));
endmodule

bind ilv_hpa_decoder ilv_hpa_decoder_chk #(.OFS_W(OFS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_ofs      (req_ofs),
    .req_ways_code(req_ways_code),
    .req_gran_code(req_gran_code),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_pos      (rsp_pos),
    .rsp_dev_ofs  (rsp_dev_ofs),
    .rsp_err      (rsp_err)
);

// File: tb/ilv_hpa_decoder_tb.sv
`timescale 1ns/1ps
module ilv_hpa_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [51:0] req_ofs = '0;
    logic [3:0]  req_ways_code = '0;
    logic [3:0]  req_gran_code = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [3:0]  rsp_pos;
    logic [51:0] rsp_dev_ofs;
    logic        rsp_err;

    int checks = 0;
    int failures = 0;
    logic done_flag = 1'b0;

    logic [3:0]  q_pos[$];
    logic [51:0] q_dev[$];
    logic        q_err[$];
    logic [51:0] q_host[$];
    int          q_gran[$];
    string       q_tag[$];

    longint unsigned seed = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    ilv_hpa_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ofs(req_ofs),
        .req_ways_code(req_ways_code), .req_gran_code(req_gran_code),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pos(rsp_pos),
        .rsp_dev_ofs(rsp_dev_ofs), .rsp_err(rsp_err)
    );

    function automatic logic [51:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed[51:0];
    endfunction

    // Independent reference built from R2..R7
    task automatic model(input logic [51:0] h, input int w, input int g,
                         output logic [3:0] p, output logic [51:0] dv,
                         output logic e, output string tag);
        longint unsigned hh, lowm, ways, qv;
        int lo;
        hh = 64'(h);
        lo = g + 8;
        lowm = (64'd1 << lo) - 1;
        if (!((w <= 4) || (w >= 8 && w <= 10)) || g > 6) begin
            e = 1'b1; p = '0; dv = '1; tag = "R7";
        end else if (w <= 4) begin
            ways = 64'd1 << w;
            e = 1'b0;
            p = 4'((hh >> lo) % ways);
            dv = 52'((((hh >> (lo + w)) << lo) | (hh & lowm)));
            tag = "R3,R4";
        end else begin
            ways = 64'd3 << (w - 8);
            e = 1'b0;
            p = 4'((hh >> lo) % ways);
            qv = (hh >> (g + w)) / 3;
            dv = 52'(((qv << lo) | (hh & lowm)));
            tag = "R5,R6";
        end
    endtask

    task automatic drive(input logic [51:0] h, input int w, input int g);
        logic [3:0] p; logic [51:0] dv; logic e; string tag;
        model(h, w, g, p, dv, e, tag);
        q_pos.push_back(p); q_dev.push_back(dv); q_err.push_back(e);
        q_host.push_back(h); q_gran.push_back(g); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_ofs = h;
        req_ways_code = 4'(w);
        req_gran_code = 4'(g);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Reference occupancy for R8, sampled at the edge
    logic busy_tb = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) busy_tb <= 1'b0;
        else if (req_valid && req_ready) busy_tb <= 1'b1;
        else if (rsp_valid && rsp_ready) busy_tb <= 1'b0;
    end

    // Monitor and scoreboard
    logic [15:0] rdy_lfsr = 16'hACE1;
    logic        hold_prev = 1'b0;
    logic [3:0]  prev_pos;
    logic [51:0] prev_dev;
    logic        prev_err;

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (busy_tb) begin
                checks++;
                if (req_ready) begin
                    failures++;
                    $display("FAIL R8 req_ready=%0b expected 0 while busy", req_ready);
                end
            end
            if (hold_prev) begin
                checks++;
                if (!rsp_valid || rsp_pos != prev_pos || rsp_dev_ofs != prev_dev || rsp_err != prev_err) begin
                    failures++;
                    $display("FAIL R9 held response changed: valid=%0b pos=%0d dev=%h err=%0b expected pos=%0d dev=%h err=%0b",
                             rsp_valid, rsp_pos, rsp_dev_ofs, rsp_err, prev_pos, prev_dev, prev_err);
                end
            end
            rdy_lfsr = {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
            rsp_ready = (rdy_lfsr[1:0] != 2'b00);
            hold_prev = rsp_valid && !rsp_ready;
            prev_pos = rsp_pos; prev_dev = rsp_dev_ofs; prev_err = rsp_err;
            if (rsp_valid && rsp_ready) begin
                if (q_pos.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R8 unexpected response pos=%0d expected none", rsp_pos);
                end else begin
                    logic [3:0] ep; logic [51:0] ed; logic ee; logic [51:0] eh; int eg; string et;
                    logic [51:0] km;
                    ep = q_pos.pop_front(); ed = q_dev.pop_front(); ee = q_err.pop_front();
                    eh = q_host.pop_front(); eg = q_gran.pop_front(); et = q_tag.pop_front();
                    checks++;
                    if (rsp_pos != ep || rsp_dev_ofs != ed || rsp_err != ee) begin
                        failures++;
                        $display("FAIL %s pos=%0d dev=%h err=%0b expected pos=%0d dev=%h err=%0b",
                                 et, rsp_pos, rsp_dev_ofs, rsp_err, ep, ed, ee);
                    end
                    if (!ee) begin
                        km = ~({52{1'b1}} << (eg + 8));
                        checks++;
                        if (((rsp_dev_ofs ^ eh) & km) != '0) begin
                            failures++;
                            $display("FAIL R2 low bits dev=%h expected low of %h", rsp_dev_ofs, eh);
                        end
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            failures++;
            $display("FAIL R8 watchdog pending=%0d expected 0", q_pos.size());
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 req_ready=%0b rsp_valid=%0b expected 1 and 0", req_ready, rsp_valid);
        end
        // Hand-picked corners
        drive(52'h0_0000_0000_0000, 8, 0);     // R5 zero offset
        drive('1, 10, 6);                      // R6 largest offset
        drive(52'h0_0000_0000_0700, 3, 0);     // R3 position field = 7
        drive(52'h0_0000_0000_ABCD, 0, 2);     // R3 no interleave, pos 0
        drive(52'h0_0000_0000_1234, 5, 0);     // R7 bad ways
        drive(52'h0_0000_0000_1234, 1, 7);     // R7 bad granule
        // Sweep every code pair
        for (int w = 0; w < 16; w++) begin
            for (int g = 0; g < 8; g++) begin
                drive('1, w, g);
                drive(next_rand(), w, g);
                drive(next_rand(), w, g);
            end
        end
        // Extra three-based traffic (R5, R6)
        for (int i = 0; i < 30; i++) begin
            drive(next_rand(), 8 + (i % 3), i % 7);
        end
        while (q_pos.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule